// File: doc/BRIEF.md
# ATM Cell Mode Frame Packer

This block gathers individual ATM cells from a byte stream and concatenates them into the payload of one tunnel frame. It does not segment or reassemble them. Each cell enters as 52 bytes: a 4-byte header without HEC, followed by 48 payload bytes. A marker flags the first byte of each cell. Cells leave unchanged and back to back on a byte output stream with a valid/ready handshake. The final byte of each frame carries an end marker.

A frame closes on any of three events: it reaches the cell cap, a flush request arrives, or the input stays silent for a programmable number of cycles. When OAM transport is switched off, the block drops any cell whose PTI high bit is set. A build option places a zero control word in front of every frame. After each frame the block reports the number of cells it held and its length in bytes.

The block holds a whole cell in a buffer before forwarding it. This allows a misaligned cell to be thrown away and an OAM cell to be screened. It also keeps back the final byte of each forwarded cell until it knows whether that byte ends the frame.

Top module: `atm_cell_packer`

## Requirements
- R1: Each forwarded cell appears on the output as its 52 bytes in arrival order and unchanged, so a frame body is always a whole multiple of 52 bytes.
- R2: A frame ends with the cell that brings its count to the cap. The cap is `cellLimit`, clamped so that 0 acts as 1 and any value above MAX_CELLS acts as MAX_CELLS. The end marker sits on byte 52 of that cell.
- R3: A flush pulse ends the open frame after any cell that is part way in has been taken. A flush when no cell is held has no effect.
- R4: When `gapCycles` is non-zero, a frame ends after `gapCycles` consecutive cycles with a cell held and no new cell begun. A value of 0 disables this timeout.
- R5: No frame without cells is ever emitted or reported.
- R6: When `oamEn` is 0, a cell is dropped entirely if bit 3 of header byte 3 is 1. Header byte 3 holds the PTI in bits 3:1 and the CLP in bit 0. When `oamEn` is 1, such cells are forwarded like any other.
- R7: With CW_EN set, every frame starts with four zero bytes (zero flags, length and sequence) before its first cell.
- R8: `rptValid` pulses for one cycle, in the cycle after the handshake of a frame's last byte. `rptCells` then gives that frame's cell count, and `rptBytes` gives 52 times the count plus 4 when CW_EN is set.
- R9: While `outValid` is high and `outReady` is low, the output byte and end marker hold steady. Input intake is stalled (`inReady` low) while the block drives output, so no byte is lost.
- R10: An `inSof` byte that arrives when a cell is part way in raises `framingErr` for one cycle, in the next cycle. The partial cell is discarded, and the marked byte starts a new cell.
- R11: After reset, `outValid`, `rptValid` and `framingErr` are low and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte valid |
| inReady | output | 1 | Block accepts an input byte |
| inSof | input | 1 | Input byte is the first byte of a cell |
| inData | input | 8 | Input byte |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Sink accepts the output byte |
| outData | output | 8 | Output byte |
| outLast | output | 1 | Output byte ends the frame |
| cellLimit | input | CNT_W | Cell cap per frame |
| gapCycles | input | GAP_W | Idle cycles before a held frame closes, 0 disables |
| oamEn | input | 1 | Forward cells with PTI high bit set |
| flush | input | 1 | Close the open frame |
| framingErr | output | 1 | Cell-start marker seen part way through a cell |
| rptValid | output | 1 | Frame report strobe |
| rptCells | output | CNT_W | Cells in the reported frame |
| rptBytes | output | LEN_W | Bytes in the reported frame |

## Verification
A wrong byte index or read pointer shows at the output within one cell time: a header or payload byte lands out of place against the reference byte queue. A wrong cell count, or a lost held byte, shows at the next frame boundary. There the end marker appears on the wrong byte, or the report carries a wrong count or length, one cycle after the final handshake. A stuck flush latch or gap timer shows as a frame that closes too early or never closes. The bench catches the latter when the expected bytes are still waiting at the end of the run.

// File: rtl/atm_pack_pkg.sv
package atm_pack_pkg;
  localparam int CELL_BYTES = 52;
  localparam int CW_BYTES   = 4;
  localparam int IDX_W      = $clog2(CELL_BYTES);
  localparam int PTI_BYTE   = 3;
  localparam int PTI_MSB    = 3;

  typedef enum logic [2:0] {ST_FILL, ST_CW, ST_PEND, ST_DRAIN, ST_LASTP} packState_t;
  typedef enum logic [1:0] {SRC_ZERO, SRC_BUF, SRC_PEND} outSrc_t;

  typedef struct packed {
    logic             bufWr;
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] rdIdx;
    outSrc_t          src;
    logic             pendLoad;
  } packStrobe_t;
endpackage

// File: rtl/atm_pack_dp.sv
module atm_pack_dp
  import atm_pack_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  packStrobe_t stb,
  input  logic [7:0]  inData,
  output logic [7:0]  outData,
  output logic        oamBit
);
  logic [7:0] cellBuf [CELL_BYTES];
  logic [7:0] pendByte;

  always_ff @(posedge clk) begin
    if (stb.bufWr) cellBuf[stb.wrIdx] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             pendByte <= '0;
    else if (stb.pendLoad) pendByte <= cellBuf[CELL_BYTES-1];
  end

  assign oamBit = cellBuf[PTI_BYTE][PTI_MSB];

  always_comb begin
    unique case (stb.src)
      SRC_BUF:  outData = cellBuf[stb.rdIdx];
      SRC_PEND: outData = pendByte;
      default:  outData = '0;
    endcase
  end
endmodule

// File: rtl/atm_pack_ctrl.sv
module atm_pack_ctrl
  import atm_pack_pkg::*;
#(
  parameter int MAX_CELLS = 8,
  parameter int GAP_W     = 8,
  parameter bit CW_EN     = 1'b1,
  parameter int CNT_W     = $clog2(MAX_CELLS + 1),
  parameter int LEN_W     = $clog2(MAX_CELLS * CELL_BYTES + CW_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSof,
  output logic             inReady,
  output logic             outValid,
  input  logic             outReady,
  output logic             outLast,
  input  logic             flush,
  input  logic [CNT_W-1:0] cellLimit,
  input  logic [GAP_W-1:0] gapCycles,
  input  logic             oamEn,
  input  logic             oamBit,
  output packStrobe_t      stb,
  output logic             framingErr,
  output logic             rptValid,
  output logic [CNT_W-1:0] rptCells,
  output logic [LEN_W-1:0] rptBytes
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

  packState_t       state;
  logic [IDX_W-1:0] wrIdx, rdIdx;
  logic [1:0]       cwCnt;
  logic [CNT_W-1:0] cellCnt, cellNext, effLimit;
  logic [GAP_W-1:0] gapCnt;
  logic             pendValid, flushReq;
  logic             timeout, closeNow, accept, misalign, cellDone, dropCell, hitLimit, xfer;

  function automatic logic [LEN_W-1:0] frameLen(input logic [CNT_W-1:0] n);
    return LEN_W'(n) * LEN_W'(CELL_BYTES) + LEN_W'(CW_EN ? CW_BYTES : 0);
  endfunction

  assign effLimit = (cellLimit == '0) ? CNT_W'(1) :
                    (cellLimit > CNT_W'(MAX_CELLS)) ? CNT_W'(MAX_CELLS) : cellLimit;
  assign cellNext = cellCnt + CNT_W'(1);
  assign hitLimit = cellNext >= effLimit;
  assign timeout  = (gapCycles != '0) && (gapCnt >= gapCycles);
  assign closeNow = (state == ST_FILL) && pendValid && (wrIdx == '0) && (flushReq || flush || timeout);
  assign inReady  = (state == ST_FILL) && !closeNow;
  assign accept   = inValid && inReady;
  assign misalign = accept && inSof && (wrIdx != '0);
  assign cellDone = accept && !misalign && (wrIdx == LAST_IDX);
  assign dropCell = oamBit && !oamEn;

  always_comb begin
    unique case (state)
      ST_CW, ST_PEND, ST_LASTP: outValid = 1'b1;
      ST_DRAIN: outValid = (rdIdx != LAST_IDX) || hitLimit;
      default:  outValid = 1'b0;
    endcase
  end
  assign outLast = (state == ST_LASTP) || ((state == ST_DRAIN) && (rdIdx == LAST_IDX) && hitLimit);
  assign xfer    = outValid && outReady;

  always_comb begin
    stb          = '0;
    stb.bufWr    = accept;
    stb.wrIdx    = misalign ? '0 : wrIdx;
    stb.rdIdx    = rdIdx;
    stb.pendLoad = (state == ST_DRAIN) && (rdIdx == LAST_IDX) && !hitLimit;
    unique case (state)
      ST_CW:             stb.src = SRC_ZERO;
      ST_PEND, ST_LASTP: stb.src = SRC_PEND;
      default:           stb.src = SRC_BUF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_FILL; wrIdx <= '0; rdIdx <= '0; cwCnt <= '0;
      cellCnt <= '0; pendValid <= 1'b0; rptValid <= 1'b0;
      rptCells <= '0; rptBytes <= '0; framingErr <= 1'b0;
    end else begin
      rptValid   <= 1'b0;
      framingErr <= misalign;
      unique case (state)
        ST_FILL: begin
          if (accept) begin
            if (misalign) wrIdx <= IDX_W'(1);
            else if (cellDone) begin
              wrIdx <= '0; rdIdx <= '0; cwCnt <= '0;
              if (!dropCell) state <= pendValid ? ST_PEND : (CW_EN ? ST_CW : ST_DRAIN);
            end else wrIdx <= wrIdx + IDX_W'(1);
          end else if (closeNow) state <= ST_LASTP;
        end
        ST_CW: if (xfer) begin
          cwCnt <= cwCnt + 2'd1;
          if (cwCnt == 2'd3) state <= ST_DRAIN;
        end
        ST_PEND: if (xfer) begin
          pendValid <= 1'b0; state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (rdIdx != LAST_IDX) begin
            if (xfer) rdIdx <= rdIdx + IDX_W'(1);
          end else if (hitLimit) begin
            if (xfer) begin
              rptValid <= 1'b1; rptCells <= cellNext; rptBytes <= frameLen(cellNext);
              cellCnt <= '0; state <= ST_FILL;
            end
          end else begin
            pendValid <= 1'b1; cellCnt <= cellNext; state <= ST_FILL;
          end
        end
        ST_LASTP: if (xfer) begin
          rptValid <= 1'b1; rptCells <= cellCnt; rptBytes <= frameLen(cellCnt);
          cellCnt <= '0; pendValid <= 1'b0; state <= ST_FILL;
        end
        default: state <= ST_FILL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= '0; flushReq <= 1'b0;
    end else begin
      if ((state == ST_FILL) && pendValid && (wrIdx == '0) && !accept) begin
        if (gapCnt != {GAP_W{1'b1}}) gapCnt <= gapCnt + GAP_W'(1);
      end else gapCnt <= '0;
      if ((state == ST_FILL) && (wrIdx == '0)) flushReq <= 1'b0;
      else if (flush) flushReq <= 1'b1;
    end
  end

  // R9: intake stalls while output is driven
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rstN) !(inReady && outValid));
  // R5: reported frames are never empty
  a_r5_nonempty: assert property (@(posedge clk) disable iff (!rstN) rptValid |-> rptCells != '0);
  // R2: reported count never exceeds the cap
  a_r2_cap: assert property (@(posedge clk) disable iff (!rstN) rptValid |-> rptCells <= CNT_W'(MAX_CELLS));
  // R8: report follows a last-byte handshake
  a_r8_after_last: assert property (@(posedge clk) disable iff (!rstN) rptValid |-> $past(outValid && outReady && outLast));
  // R10: framing error only after a marked input byte
  a_r10_cause: assert property (@(posedge clk) disable iff (!rstN) framingErr |-> $past(inValid && inSof));
endmodule

// File: rtl/atm_cell_packer.sv
module atm_cell_packer
  import atm_pack_pkg::*;
#(
  parameter int MAX_CELLS = 8,
  parameter int GAP_W     = 8,
  parameter bit CW_EN     = 1'b1,
  parameter int CNT_W     = $clog2(MAX_CELLS + 1),
  parameter int LEN_W     = $clog2(MAX_CELLS * CELL_BYTES + CW_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic             inSof,
  input  logic [7:0]       inData,
  output logic             outValid,
  input  logic             outReady,
  output logic [7:0]       outData,
  output logic             outLast,
  input  logic [CNT_W-1:0] cellLimit,
  input  logic [GAP_W-1:0] gapCycles,
  input  logic             oamEn,
  input  logic             flush,
  output logic             framingErr,
  output logic             rptValid,
  output logic [CNT_W-1:0] rptCells,
  output logic [LEN_W-1:0] rptBytes
);
  packStrobe_t stb;
  logic        oamBit;

  atm_pack_ctrl #(
    .MAX_CELLS(MAX_CELLS), .GAP_W(GAP_W), .CW_EN(CW_EN), .CNT_W(CNT_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outLast(outLast), .flush(flush),
    .cellLimit(cellLimit), .gapCycles(gapCycles), .oamEn(oamEn), .oamBit(oamBit),
    .stb(stb), .framingErr(framingErr), .rptValid(rptValid),
    .rptCells(rptCells), .rptBytes(rptBytes)
  );

  atm_pack_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData), .outData(outData), .oamBit(oamBit)
  );

  // R9: a stalled output byte holds its value and marker
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));
endmodule

// File: tb/tb_atm_cell_packer.sv
module tb_atm_cell_packer;
  localparam int CLK_PERIOD = 10;
  localparam int MAXC = 8;
  localparam int CNTW = $clog2(MAXC + 1);
  localparam int LENW = $clog2(MAXC * 52 + 5);
  localparam int GAPW = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 1'b0, inSof = 1'b0, outReady = 1'b1, oamEn = 1'b0, flush = 1'b0;
  logic [7:0] inData = '0;
  logic [CNTW-1:0] cellLimit = CNTW'(3);
  logic [GAPW-1:0] gapCycles = GAPW'(20);
  logic inReady, outValid, outLast, framingErr, rptValid;
  logic [7:0] outData;
  logic [CNTW-1:0] rptCells;
  logic [LENW-1:0] rptBytes;

  atm_cell_packer #(.MAX_CELLS(MAXC), .GAP_W(GAPW), .CW_EN(1'b1)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inSof(inSof),
    .inData(inData), .outValid(outValid), .outReady(outReady), .outData(outData),
    .outLast(outLast), .cellLimit(cellLimit), .gapCycles(gapCycles), .oamEn(oamEn),
    .flush(flush), .framingErr(framingErr), .rptValid(rptValid), .rptCells(rptCells),
    .rptBytes(rptBytes)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nCmp = 0, nBad = 0, cyc = 0, rptSeen = 0, errSeen = 0;
  bit randReady = 0, rptDue = 0;
  logic [8:0] expQ[$];
  int rptQ[$];
  int frameCells = 0;
  bit pendHave = 0;
  logic [7:0] pendB;

  task automatic chk(input string req, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int effLim(input int l);
    return (l == 0) ? 1 : ((l > MAXC) ? MAXC : l);
  endfunction

  function automatic logic [7:0] byteOf(input logic [31:0] hdr, input logic [7:0] seed, input int k);
    return (k < 4) ? hdr[31-8*k -: 8] : seed + 8'(k);
  endfunction

  task automatic mdlCell(input logic [31:0] hdr, input logic [7:0] seed);
    if (hdr[3] && !oamEn) return;
    if (frameCells == 0) for (int i = 0; i < 4; i++) expQ.push_back(9'h000);
    if (pendHave) begin expQ.push_back({1'b0, pendB}); pendHave = 0; end
    for (int k = 0; k < 51; k++) expQ.push_back({1'b0, byteOf(hdr, seed, k)});
    frameCells++;
    if (frameCells >= effLim(int'(cellLimit))) begin
      expQ.push_back({1'b1, byteOf(hdr, seed, 51)});
      rptQ.push_back(frameCells);
      frameCells = 0;
    end else begin
      pendB = byteOf(hdr, seed, 51);
      pendHave = 1;
    end
  endtask

  task automatic mdlClose();
    if (pendHave) begin
      expQ.push_back({1'b1, pendB});
      rptQ.push_back(frameCells);
      frameCells = 0;
      pendHave = 0;
    end
  endtask

  always @(negedge clk) begin
    outReady = randReady ? ($urandom_range(2) != 0) : 1'b1;
    if (rstN) begin
      if (rptDue || rptValid) chk("R8 report timing", int'(rptValid), int'(rptDue));
      rptDue = 0;
      if (outValid && outReady) begin
        if (expQ.size() == 0) chk("R5 unexpected output byte", 1, 0);
        else begin
          logic [8:0] e;
          e = expQ.pop_front();
          chk("R1 R6 R7 byte data", int'(outData), int'(e[7:0]));
          chk("R2 R3 R4 last marker", int'(outLast), int'(e[8]));
        end
        rptDue = outLast;
      end
      if (rptValid) begin
        rptSeen++;
        if (rptQ.size() == 0) chk("R5 unexpected report", 1, 0);
        else begin
          int c;
          c = rptQ.pop_front();
          chk("R8 report cells", int'(rptCells), c);
          chk("R8 report bytes", int'(rptBytes), c * 52 + 4);
        end
      end
      if (framingErr) errSeen++;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nBad++;
      $display("FAIL R9 watchdog actual %0d expected below 150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic putByte(input logic [7:0] b, input logic s);
    @(negedge clk);
    inValid = 1'b1; inData = b; inSof = s;
    while (!inReady) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic sendCell(input logic [31:0] hdr, input logic [7:0] seed, input bit jitter);
    mdlCell(hdr, seed);
    for (int k = 0; k < 52; k++) begin
      putByte(byteOf(hdr, seed, k), k == 0);
      if (jitter && $urandom_range(3) == 0) begin
        @(negedge clk); inValid = 1'b0;
      end
    end
    @(negedge clk); inValid = 1'b0; inSof = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doFlush();
    mdlClose();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic waitDrain();
    for (int i = 0; i < 3000 && (expQ.size() != 0 || rptQ.size() != 0); i++) @(negedge clk);
    idle(3);
  endtask

  initial begin
    int r0, e0;
    idle(4);
    chk("R11 reset outValid", int'(outValid), 0);
    chk("R11 reset rptValid", int'(rptValid), 0);
    chk("R11 reset framingErr", int'(framingErr), 0);
    chk("R11 reset inReady", int'(inReady), 1);
    rstN = 1'b1;
    idle(2);

    // R1 R2 R7: three cells close on the cap of 3
    sendCell(32'h0120_3452, 8'h10, 0);
    sendCell(32'h0120_3454, 8'h40, 0);
    sendCell(32'h0120_3451, 8'h70, 0);
    waitDrain();
    chk("R2 reports after cap", rptSeen, 1);

    // R9 R4: backpressure with jitter, tail closed by the gap timeout
    randReady = 1;
    for (int c = 0; c < 5; c++) sendCell(32'hA5B0_0000 | c, 8'(c * 17), 1);
    mdlClose();
    idle(80);
    waitDrain();
    chk("R4 timeout closes tail", rptSeen, 3);
    randReady = 0;

    // R6: OAM cells dropped, then forwarded
    sendCell(32'h0001_0008, 8'h20, 0);
    sendCell(32'h0001_0002, 8'h30, 0);
    sendCell(32'h0001_000E, 8'h50, 0);
    doFlush();
    waitDrain();
    chk("R6 OAM cells dropped", rptSeen, 4);
    oamEn = 1'b1;
    sendCell(32'h0001_0009, 8'h60, 0);
    doFlush();
    waitDrain();
    oamEn = 1'b0;
    chk("R6 OAM cell forwarded", rptSeen, 5);

    // R3: flush with nothing held has no effect
    r0 = rptSeen;
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    idle(40);
    chk("R3 empty flush ignored", rptSeen, r0);
    chk("R5 empty flush no output", int'(outValid), 0);

    // R10: misaligned cell start
    e0 = errSeen;
    for (int k = 0; k < 20; k++) putByte(8'hEE, k == 0);
    sendCell(32'h0777_0010, 8'h80, 0);
    doFlush();
    waitDrain();
    chk("R10 framing error count", errSeen, e0 + 1);

    // R2: clamp of cap 0 to 1 and of 12 to MAXC
    cellLimit = '0;
    sendCell(32'h0300_0020, 8'h01, 0);
    sendCell(32'h0300_0030, 8'h02, 0);
    waitDrain();
    chk("R2 cap zero acts as one", rptSeen, r0 + 3);
    cellLimit = CNTW'(12);
    for (int c = 0; c < 9; c++) sendCell(32'h0400_0000 | (c << 4), 8'(c * 5), 0);
    doFlush();
    waitDrain();
    chk("R2 cap above max clamps", rptSeen, r0 + 5);

    // R4: timeout disabled holds the frame open
    cellLimit = CNTW'(3);
    gapCycles = '0;
    r0 = rptSeen;
    sendCell(32'h0500_0040, 8'h90, 0);
    idle(150);
    chk("R4 zero gap keeps frame open", rptSeen, r0);
    doFlush();
    waitDrain();
    chk("R3 flush closes frame", rptSeen, r0 + 1);

    chk("R5 leftover expected bytes", expQ.size(), 0);
    chk("R8 leftover expected reports", rptQ.size(), 0);
    summary();
    $finish;
  end
endmodule